// File: doc/BRIEF.md
# Two-Road Signal Controller with Protected Turn Phases

This block drives the lamps of a two-road crossing, with one road running north-south and the other east-west. Each road in turn gets a green phase and then one cycle of yellow. After the yellow, if that road's turn-lane sensor is asserted, the road gets one cycle of protected arrow and one cycle of yellow arrow. Then the other road gets green. The outputs are a pure function of the registered state, so every lamp changes only at a clock edge.

The length of a green phase is set by one green state and a cycle counter, not by a chain of states. `GREEN_CYCLES` sets how many cycles a green phase lasts. The parameter `HOLD_MODE` adds a variant. In that variant a road whose green has run its full length keeps green for as long as the crossing road reports no waiting traffic. It leaves green on the first edge at which that traffic is reported.

Top module: `xing_light_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, and on the first cycle after it falls, the controller is in north-south green. In that state only `ns_grn` and `ew_red` are 1, and the green counter is cleared.
- R2: In every state exactly two lamps are lit. In a north-south state `ew_red` is 1 and `ns_red` is 0. In an east-west state `ns_red` is 1 and `ew_red` is 0. The other lit lamp is `*_grn` in green, `*_ylw` in yellow, `*_grn_arw` in arrow and `*_ylw_arw` in yellow-arrow, for the road that has right of way.
- R3: In the normal mode, a north-south green phase lasts exactly `GREEN_CYCLES` cycles and is followed by exactly one cycle of north-south yellow.
- R4: From north-south yellow, the controller goes to north-south arrow if `ns_arrow_req` is 1 at that edge, and otherwise goes straight to east-west green. Arrow always lasts one cycle and leads to one cycle of yellow-arrow. Yellow-arrow always leads to east-west green.
- R5: The east-west road mirrors R3 and R4. It uses `ew_arrow_req`, and after east-west yellow or yellow-arrow the controller returns to north-south green.
- R6: A turn request has no effect unless it is present at the edge that leaves that road's yellow state.
- R7: With `HOLD_MODE` = 1, a green phase that has reached `GREEN_CYCLES` cycles stays green while the crossing road's `*_waiting` input is 0. It moves to yellow at the first edge at which that input is 1.
- R8: With `HOLD_MODE` = 0, the inputs `ns_waiting` and `ew_waiting` have no effect on the lamps.
- R9: The green counter restarts on every entry into a green state, so every green phase gets the full `GREEN_CYCLES` count, whatever the earlier phases did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ns_arrow_req | input | 1 | North-south turn-lane car detected |
| ew_arrow_req | input | 1 | East-west turn-lane car detected |
| ns_waiting | input | 1 | North-south traffic present (used in hold mode) |
| ew_waiting | input | 1 | East-west traffic present (used in hold mode) |
| ns_grn | output | 1 | North-south green |
| ns_grn_arw | output | 1 | North-south green arrow |
| ns_ylw | output | 1 | North-south yellow |
| ns_ylw_arw | output | 1 | North-south yellow arrow |
| ns_red | output | 1 | North-south red |
| ew_grn | output | 1 | East-west green |
| ew_grn_arw | output | 1 | East-west green arrow |
| ew_ylw | output | 1 | East-west yellow |
| ew_ylw_arw | output | 1 | East-west yellow arrow |
| ew_red | output | 1 | East-west red |

## Verification
The assertions assume that all four sensor inputs are synchronous to `clk` and settle before each rising edge. They also assume that `rst` is held for at least one edge before the first phase is judged. The bench meets this by changing every input only on the falling edge. It sweeps the inputs through steady patterns and through pseudo-random toggling, so that turn requests fall both inside and outside the yellow cycles. In hold mode it keeps the waiting inputs low for long stretches, so that green is held well past its nominal length.

// File: rtl/xing_light_fsm.sv
module xing_light_fsm #(
  parameter int GREEN_CYCLES = 200,
  parameter int HOLD_MODE    = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic ns_arrow_req,
  input  logic ew_arrow_req,
  input  logic ns_waiting,
  input  logic ew_waiting,
  output logic ns_grn,
  output logic ns_grn_arw,
  output logic ns_ylw,
  output logic ns_ylw_arw,
  output logic ns_red,
  output logic ew_grn,
  output logic ew_grn_arw,
  output logic ew_ylw,
  output logic ew_ylw_arw,
  output logic ew_red
);
  localparam int CW = $clog2(GREEN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(GREEN_CYCLES - 1);
  localparam bit HOLD = (HOLD_MODE != 0);

  localparam logic [2:0] S_NG = 3'd0, S_NY = 3'd1, S_NA = 3'd2, S_NAY = 3'd3;
  localparam logic [2:0] S_EG = 3'd4, S_EY = 3'd5, S_EA = 3'd6, S_EAY = 3'd7;

  logic [2:0]    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_green, grn_done, cross_go;

  assign in_green = (state_q[1:0] == 2'd0);
  assign grn_done = (cnt_q == LAST);
  assign cross_go = !HOLD || (state_q[2] ? ns_waiting : ew_waiting);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_NG:    if (grn_done && cross_go) state_d = S_NY;
      S_NY:    state_d = ns_arrow_req ? S_NA : S_EG;
      S_NA:    state_d = S_NAY;
      S_NAY:   state_d = S_EG;
      S_EG:    if (grn_done && cross_go) state_d = S_EY;
      S_EY:    state_d = ew_arrow_req ? S_EA : S_NG;
      S_EA:    state_d = S_EAY;
      default: state_d = S_NG;
    endcase
  end

  always_comb begin
    if (!in_green || state_d != state_q) cnt_d = '0;
    else if (!grn_done)                  cnt_d = cnt_q + 1'b1;
    else                                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_NG;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  logic ew_side;
  assign ew_side = state_q[2];

  assign ns_red     =  ew_side;
  assign ew_red     = !ew_side;
  assign ns_grn     = !ew_side && state_q[1:0] == 2'd0;
  assign ns_ylw     = !ew_side && state_q[1:0] == 2'd1;
  assign ns_grn_arw = !ew_side && state_q[1:0] == 2'd2;
  assign ns_ylw_arw = !ew_side && state_q[1:0] == 2'd3;
  assign ew_grn     =  ew_side && state_q[1:0] == 2'd0;
  assign ew_ylw     =  ew_side && state_q[1:0] == 2'd1;
  assign ew_grn_arw =  ew_side && state_q[1:0] == 2'd2;
  assign ew_ylw_arw =  ew_side && state_q[1:0] == 2'd3;
endmodule

// File: rtl/xing_light_fsm_chk.sv
module xing_light_fsm_chk #(
  parameter int GREEN_CYCLES = 200,
  parameter int HOLD_MODE    = 0
) (
  input logic clk,
  input logic rst,
  input logic ns_arrow_req,
  input logic ew_arrow_req,
  input logic ns_waiting,
  input logic ew_waiting,
  input logic ns_grn,
  input logic ns_grn_arw,
  input logic ns_ylw,
  input logic ns_ylw_arw,
  input logic ns_red,
  input logic ew_grn,
  input logic ew_grn_arw,
  input logic ew_ylw,
  input logic ew_ylw_arw,
  input logic ew_red
);
  logic [9:0] lamps;
  assign lamps = {ns_grn, ns_grn_arw, ns_ylw, ns_ylw_arw, ns_red,
                  ew_grn, ew_grn_arw, ew_ylw, ew_ylw_arw, ew_red};

  int ns_run_q, ew_run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      ns_run_q <= 0;
      ew_run_q <= 0;
    end else begin
      ns_run_q <= ns_grn ? ns_run_q + 1 : 0;
      ew_run_q <= ew_grn ? ew_run_q + 1 : 0;
    end
  end

  p_two_lit_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(lamps) == 2 && (ns_red != ew_red));
  p_ns_red_side_r2: assert property (@(posedge clk) disable iff (rst)
    ns_red |-> !(ns_grn || ns_grn_arw || ns_ylw || ns_ylw_arw));
  p_ns_len_r3: assert property (@(posedge clk) disable iff (rst)
    (HOLD_MODE == 0 && ns_grn) |-> ns_run_q < GREEN_CYCLES);
  p_ns_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (HOLD_MODE == 0 && ns_grn && ns_run_q == GREEN_CYCLES - 1) |=> ns_ylw);
  p_ns_arw_r4: assert property (@(posedge clk) disable iff (rst)
    (ns_ylw && ns_arrow_req) |=> ns_grn_arw);
  p_ns_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (ns_ylw && !ns_arrow_req) |=> ew_grn);
  p_ns_yarw_r4: assert property (@(posedge clk) disable iff (rst)
    ns_grn_arw |=> ns_ylw_arw);
  p_ns_hand_r4: assert property (@(posedge clk) disable iff (rst)
    ns_ylw_arw |=> ew_grn);
  p_ew_len_r5: assert property (@(posedge clk) disable iff (rst)
    (HOLD_MODE == 0 && ew_grn) |-> ew_run_q < GREEN_CYCLES);
  p_ew_arw_r5: assert property (@(posedge clk) disable iff (rst)
    (ew_ylw && ew_arrow_req) |=> ew_grn_arw);
  p_ew_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (ew_ylw && !ew_arrow_req) |=> ns_grn);
  p_ew_hand_r5: assert property (@(posedge clk) disable iff (rst)
    ew_ylw_arw |=> ns_grn);
  p_ns_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (HOLD_MODE != 0 && ns_grn && !ew_waiting) |=> ns_grn);
  p_ew_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (HOLD_MODE != 0 && ew_grn && !ns_waiting) |=> ew_grn);
endmodule

bind xing_light_fsm xing_light_fsm_chk #(
  .GREEN_CYCLES(GREEN_CYCLES), .HOLD_MODE(HOLD_MODE)
) u_chk (.*);

// File: tb/xing_light_fsm_bench.sv
`timescale 1ns/1ps
module xing_light_fsm_bench;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ns_req = 1'b0, ew_req = 1'b0, ns_wait = 1'b1, ew_wait = 1'b1;
  logic [9:0] lamp_n, lamp_h;
  int vectors = 0, fails = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  xing_light_fsm #(.GREEN_CYCLES(G), .HOLD_MODE(0)) u_xing_light_fsm (
    .clk(clk), .rst(rst), .ns_arrow_req(ns_req), .ew_arrow_req(ew_req),
    .ns_waiting(ns_wait), .ew_waiting(ew_wait),
    .ns_grn(lamp_n[9]), .ns_grn_arw(lamp_n[8]), .ns_ylw(lamp_n[7]),
    .ns_ylw_arw(lamp_n[6]), .ns_red(lamp_n[5]),
    .ew_grn(lamp_n[4]), .ew_grn_arw(lamp_n[3]), .ew_ylw(lamp_n[2]),
    .ew_ylw_arw(lamp_n[1]), .ew_red(lamp_n[0]));

  xing_light_fsm #(.GREEN_CYCLES(G), .HOLD_MODE(1)) u_xing_light_fsm_hold (
    .clk(clk), .rst(rst), .ns_arrow_req(ns_req), .ew_arrow_req(ew_req),
    .ns_waiting(ns_wait), .ew_waiting(ew_wait),
    .ns_grn(lamp_h[9]), .ns_grn_arw(lamp_h[8]), .ns_ylw(lamp_h[7]),
    .ns_ylw_arw(lamp_h[6]), .ns_red(lamp_h[5]),
    .ew_grn(lamp_h[4]), .ew_grn_arw(lamp_h[3]), .ew_ylw(lamp_h[2]),
    .ew_ylw_arw(lamp_h[1]), .ew_red(lamp_h[0]));

  // model state: 0 green, 1 yellow, 2 arrow, 3 yellow arrow; +4 for east-west
  int st_n = 0, cn_n = 0, st_h = 0, cn_h = 0;

  function automatic logic [9:0] expect_lamps(int st);
    logic [9:0] v = '0;
    int ph = st % 4;
    if (st < 4) begin
      v[0] = 1'b1;
      v[9 - ph] = 1'b1;
      if (ph == 1) begin v[8] = 1'b1; v[7] = 1'b1; v[9] = 1'b0; v[8] = 1'b0; end
    end else begin
      v[5] = 1'b1;
      v[4 - ph] = 1'b1;
      if (ph == 1) begin v[3] = 1'b1; v[2] = 1'b1; v[4] = 1'b0; v[3] = 1'b0; end
    end
    if (ph == 2) begin v[(st < 4) ? 7 : 2] = 1'b0; v[(st < 4) ? 8 : 3] = 1'b1; end
    if (ph == 3) v[(st < 4) ? 6 : 1] = 1'b1;
    if (ph == 3) begin v[(st < 4) ? 9 : 4] = 1'b0; v[(st < 4) ? 7 : 2] = 1'b0;
                        v[(st < 4) ? 8 : 3] = 1'b0; end
    return v;
  endfunction

  task automatic model_step(inout int st, inout int cn, input bit hold);
    int nx = st;
    if (rst) begin st = 0; cn = 0; return; end
    case (st)
      0: if (cn >= G - 1 && (!hold || ew_wait)) nx = 1;
      1: nx = ns_req ? 2 : 4;
      2: nx = 3;
      3: nx = 4;
      4: if (cn >= G - 1 && (!hold || ns_wait)) nx = 5;
      5: nx = ew_req ? 6 : 0;
      6: nx = 7;
      default: nx = 0;
    endcase
    if ((st % 4) == 0 && nx == st) cn = (cn < G - 1) ? cn + 1 : cn;
    else cn = 0;
    st = nx;
  endtask

  task automatic compare(string who, logic [9:0] got, int st);
    logic [9:0] exp = expect_lamps(st);
    string rtag;
    vectors++;
    if (st == 0 || st == 4) rtag = (st == 0) ? "R3" : "R5";
    else rtag = (st < 4) ? "R4" : "R5";
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s R2 %s state %0d: got %b expected %b", tag, rtag, who, st, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare("normal", lamp_n, st_n);
    compare("hold", lamp_h, st_h);
  endtask

  task automatic advance();
    model_step(st_n, cn_n, 1'b0);
    model_step(st_h, cn_h, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog R1 got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed = 32'h1ace;
    // R1: held reset, then first cycle after release
    for (int i = 0; i < 3; i++) begin advance(); tick(); end
    rst = 1'b0;
    advance();
    tick();
    // R3, R4, R5, R9: plain cycling, no turn requests, traffic everywhere
    tag = "R9";
    for (int i = 0; i < 60; i++) begin advance(); tick(); end
    // R4, R5: turn requests held high; R8: waiting low leaves normal unit alone
    tag = "R8";
    ns_req = 1'b1; ew_req = 1'b1; ns_wait = 1'b0; ew_wait = 1'b0;
    for (int i = 0; i < 40; i++) begin advance(); tick(); end
    // R7: release waiting traffic, hold unit must leave green
    tag = "R7";
    ns_wait = 1'b1; ew_wait = 1'b1; ns_req = 1'b0; ew_req = 1'b0;
    for (int i = 0; i < 30; i++) begin advance(); tick(); end
    ew_wait = 1'b0;
    for (int i = 0; i < 25; i++) begin advance(); tick(); end
    ew_wait = 1'b1;
    for (int i = 0; i < 25; i++) begin advance(); tick(); end
    // R6: requests toggling at arbitrary times; only the yellow edge counts
    tag = "R6";
    for (int i = 0; i < 2000; i++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >>> 17);
      seed = seed ^ (seed << 5);
      ns_req = seed[3]; ew_req = seed[7];
      ns_wait = seed[11] | seed[12]; ew_wait = seed[19] | seed[20];
      advance();
      tick();
    end
    // R1: reset again mid-run
    tag = "R1";
    rst = 1'b1;
    advance(); tick();
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin advance(); tick(); end
    finish_run();
  end
endmodule